// File: doc/BRIEF.md
# Command Stream Sequencer with Call Stack

This block is the front end of a command-stream processor. It fetches 64-bit instruction words from a buffer given by a start byte address and a byte length. It executes the register and control instructions itself and retires all others as no-operations. It holds a file of 32-bit registers that 64-bit operands use in pairs. A called buffer runs as a subroutine. No explicit return instruction exists: reaching the end of a called buffer returns to the caller. Each stack frame therefore saves both the resume pointer and the caller's end pointer.

A start pulse, taken only while the block is idle, begins a run. Words are requested over a valid/ready fetch port and come back on a separate response strobe one or more cycles later. The block never requests a word at or beyond the end of the current buffer. Done rises when the root buffer is exhausted or when an error stops execution. Done, the error flag and the error code stay put until the next start. The register file keeps its contents across runs and can be read through an observation port.

Top module: `cseq_top`

## Requirements
- R1: A start pulse while idle clears done, error and the stack depth, and begins fetching at start_addr/8. If start_addr or start_len is not a multiple of 8, done and error set at once with err_code 2 and no word is fetched.
- R2: req_addr is a word pointer (byte address divided by 8). While req_valid is high and req_ready is low, req_valid and req_addr hold. No fetch is ever issued with the pointer equal to the buffer end, so a zero-length root finishes with no fetch and no error.
- R3: Opcode is bits [63:56], destination field d is [55:48] and source field s is [47:40]. Opcode 0x01 writes imm[31:0] of the 48-bit immediate in [47:0] to register d and {16'h0, imm[47:32]} to register d+1.
- R4: Opcode 0x02 writes the 32-bit immediate in [31:0] to register d.
- R5: Opcode 0x10 writes register s plus the 32-bit immediate, modulo 2^32, to register d.
- R6: Opcode 0x11 reads {s+1, s} as one 64-bit value, adds the sign-extended 32-bit immediate, and writes the sum to {d+1, d} with carry across the halves.
- R7: Opcode 0x21 (call) takes the target byte address from pair {d+1, d} and the byte length from register s. It saves the following word and the current end, runs the target buffer, then resumes at the word after the call.
- R8: When several nested buffers end together, all of their frames unwind with no extra fetch, and the next fetch is the caller's next word.
- R9: With 7 frames already saved, a call stops execution with done, error and err_code 1.
- R10: A call or jump whose length or target address is not a multiple of 8 stops execution with err_code 2.
- R11: Opcode 0x20 (jump) replaces the current buffer without saving a frame, so the end of the jumped-to buffer returns to the caller. A jump at root level stops with err_code 3.
- R12: Any other opcode only advances the pointer and writes no register. Done is sticky while idle, error always comes with done, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_addr | input | PTR_W+3 | Root buffer byte address |
| start_len | input | 32 | Root buffer byte length |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Fetch request accepted |
| req_addr | output | PTR_W | Fetch word address |
| rsp_valid | input | 1 | Fetched word valid |
| rsp_data | input | 64 | Fetched instruction word |
| dbg_idx | input | 8 | Register observation index |
| dbg_data | output | 32 | Register observation value (0 beyond the file) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished (sticky) |
| error | output | 1 | Run stopped by an error (sticky) |
| err_code | output | 2 | 0 none, 1 stack overflow, 2 alignment, 3 root jump |

## Verification
The bench builds the block with its default parameters: 96 registers, 7 saved frames and 32-bit word pointers. A 7-frame stack puts overflow within reach of a self-calling buffer after ten fetches, and the bench checks the exact fetch count. The fetch model holds 128 words, with a random ready and a random one-to-three-cycle latency. This covers stall-and-hold on the request side. Random straight-line programs on a block of 16 registers exercise carries and sign extension against a bench model.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

    localparam int INSTR_W = 64;
    localparam int REG_W   = 32;
    localparam int FIELD_W = 8;

    localparam logic [7:0] OPC_MOVE64 = 8'h01;
    localparam logic [7:0] OPC_MOVE32 = 8'h02;
    localparam logic [7:0] OPC_ADDI32 = 8'h10;
    localparam logic [7:0] OPC_ADDI64 = 8'h11;
    localparam logic [7:0] OPC_JUMP   = 8'h20;
    localparam logic [7:0] OPC_CALL   = 8'h21;

    typedef enum logic [2:0] {
        K_NOP, K_MOVE64, K_MOVE32, K_ADD32, K_ADD64, K_JUMP, K_CALL
    } kind_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0, ERR_OVERFLOW = 2'd1, ERR_ALIGN = 2'd2, ERR_ROOT_JUMP = 2'd3
    } err_e;

    typedef enum logic [1:0] { ST_IDLE, ST_FETCH, ST_WAIT } fsm_e;

    typedef struct packed {
        kind_e              kind;
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] src;
        logic [47:0]        imm48;
        logic [31:0]        imm32;
    } instr_t;

endpackage

// File: rtl/cseq_decode.sv
module cseq_decode
    import cseq_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output instr_t             ins
);
    always_comb begin
        ins.dst   = word[55:48];
        ins.src   = word[47:40];
        ins.imm48 = word[47:0];
        ins.imm32 = word[31:0];
        unique case (word[63:56])
            OPC_MOVE64: ins.kind = K_MOVE64;
            OPC_MOVE32: ins.kind = K_MOVE32;
            OPC_ADDI32: ins.kind = K_ADD32;
            OPC_ADDI64: ins.kind = K_ADD64;
            OPC_JUMP:   ins.kind = K_JUMP;
            OPC_CALL:   ins.kind = K_CALL;
            default:    ins.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/cseq_regfile.sv
module cseq_regfile #(
    parameter int NREGS  = 96,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9,
    parameter int NRD    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data,
    input  logic                        we0,
    input  logic [IDX_W-1:0]            wi0,
    input  logic [DATA_W-1:0]           wd0,
    input  logic                        we1,
    input  logic [IDX_W-1:0]            wi1,
    input  logic [DATA_W-1:0]           wd1
);
    localparam int SEL_W = $clog2(NREGS);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NREGS);

    logic [DATA_W-1:0] regs_q [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (we1 && wi1 == IDX_W'(i))      regs_q[i] <= wd1;
                else if (we0 && wi0 == IDX_W'(i)) regs_q[i] <= wd0;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] < LIMIT) ? regs_q[rd_idx[p][SEL_W-1:0]] : '0;
    end

    // R4
    wr_port0_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && wi0 < LIMIT && !(we1 && wi1 == wi0)) |=>
            regs_q[$past(wi0[SEL_W-1:0])] == $past(wd0));

    // R3
    wr_port1_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we1 && wi1 < LIMIT) |=> regs_q[$past(wi1[SEL_W-1:0])] == $past(wd1));
endmodule

// File: rtl/cseq_frame_stack.sv
module cseq_frame_stack #(
    parameter int DEPTH = 7,
    parameter int PTR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  logic [PTR_W-1:0] push_ret,
    input  logic [PTR_W-1:0] push_end,
    output logic [PTR_W-1:0] top_ret,
    output logic [PTR_W-1:0] top_end,
    output logic [CNT_W-1:0] depth,
    output logic             full,
    output logic             empty
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0] depth_d, depth_q;
    logic [PTR_W-1:0] ret_q [DEPTH];
    logic [PTR_W-1:0] end_q [DEPTH];
    logic [CNT_W-1:0] top_idx;

    assign full    = (depth_q == CNT_W'(DEPTH));
    assign empty   = (depth_q == '0);
    assign depth   = depth_q;
    assign top_idx = depth_q - CNT_W'(1);
    assign top_ret = empty ? '0 : ret_q[IW'(top_idx)];
    assign top_end = empty ? '0 : end_q[IW'(top_idx)];

    always_comb begin
        depth_d = depth_q;
        if (clear)              depth_d = '0;
        else if (push && !full) depth_d = depth_q + CNT_W'(1);
        else if (pop && !empty) depth_d = depth_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ret_q[i] <= '0;
                end_q[i] <= '0;
            end
        end else begin
            depth_q <= depth_d;
            for (int i = 0; i < DEPTH; i++) begin
                if (push && !clear && !full && depth_q == CNT_W'(i)) begin
                    ret_q[i] <= push_ret;
                    end_q[i] <= push_end;
                end
            end
        end
    end

    // R9
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R7
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |=> depth == $past(depth) + CNT_W'(1));
endmodule

// File: rtl/cseq_top.sv
module cseq_top
    import cseq_pkg::*;
#(
    parameter int NREGS       = 96,
    parameter int STACK_DEPTH = 7,
    parameter int PTR_W       = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PTR_W+2:0]   start_addr,
    input  logic [31:0]        start_len,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [PTR_W-1:0]   req_addr,
    input  logic               rsp_valid,
    input  logic [63:0]        rsp_data,
    input  logic [7:0]         dbg_idx,
    output logic [31:0]        dbg_data,
    output logic               busy,
    output logic               done,
    output logic               error,
    output logic [1:0]         err_code
);
    localparam int RIDX_W = FIELD_W + 1;
    localparam int CNT_W  = $clog2(STACK_DEPTH + 1);

    typedef struct packed {
        fsm_e             fsm;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] endp;
        logic             done;
        logic             error;
        err_e             code;
    } state_t;

    state_t st_d, st_q;

    instr_t ins;
    cseq_decode u_dec (.word(rsp_data), .ins(ins));

    logic [3:0][RIDX_W-1:0] rd_idx;
    logic [3:0][REG_W-1:0]  rd_data;
    logic                   we0, we1;
    logic [RIDX_W-1:0]      wi0, wi1;
    logic [REG_W-1:0]       wd0, wd1;

    logic [RIDX_W-1:0] dst9, src9, pair_idx;
    logic              is_xfer;
    assign dst9     = {1'b0, ins.dst};
    assign src9     = {1'b0, ins.src};
    assign is_xfer  = (ins.kind == K_CALL) || (ins.kind == K_JUMP);
    assign pair_idx = is_xfer ? dst9 : src9;
    assign rd_idx[0] = pair_idx;
    assign rd_idx[1] = pair_idx + RIDX_W'(1);
    assign rd_idx[2] = src9;
    assign rd_idx[3] = {1'b0, dbg_idx};

    cseq_regfile #(.NREGS(NREGS), .DATA_W(REG_W), .IDX_W(RIDX_W), .NRD(4)) u_rf (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .we0(we0), .wi0(wi0), .wd0(wd0), .we1(we1), .wi1(wi1), .wd1(wd1)
    );

    logic             stk_clear, stk_push, stk_pop, stk_full, stk_empty;
    logic [PTR_W-1:0] top_ret, top_end;
    logic [CNT_W-1:0] stk_depth;

    cseq_frame_stack #(.DEPTH(STACK_DEPTH), .PTR_W(PTR_W)) u_stk (
        .clk(clk), .rst_n(rst_n), .clear(stk_clear), .push(stk_push), .pop(stk_pop),
        .push_ret(st_q.ptr + PTR_W'(1)), .push_end(st_q.endp),
        .top_ret(top_ret), .top_end(top_end), .depth(stk_depth),
        .full(stk_full), .empty(stk_empty)
    );

    logic [63:0]      pair_val, add64_sum;
    logic [31:0]      len_val;
    logic [PTR_W-1:0] tgt_word, tgt_len_words, root_word, root_len_words;
    logic             tgt_bad, root_bad;

    assign pair_val       = {rd_data[1], rd_data[0]};
    assign len_val        = rd_data[2];
    assign add64_sum      = pair_val + {{32{ins.imm32[31]}}, ins.imm32};
    assign tgt_word       = pair_val[PTR_W+2:3];
    assign tgt_len_words  = PTR_W'(len_val >> 3);
    assign tgt_bad        = (len_val[2:0] != 3'd0) || (pair_val[2:0] != 3'd0);
    assign root_word      = start_addr[PTR_W+2:3];
    assign root_len_words = PTR_W'(start_len >> 3);
    assign root_bad       = (start_len[2:0] != 3'd0) || (start_addr[2:0] != 3'd0);

    always_comb begin
        st_d      = st_q;
        stk_clear = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        we0 = 1'b0; wi0 = '0; wd0 = '0;
        we1 = 1'b0; wi1 = '0; wd1 = '0;
        req_valid = 1'b0;
        unique case (st_q.fsm)
            ST_IDLE: begin
                if (start) begin
                    stk_clear  = 1'b1;
                    st_d.ptr   = root_word;
                    st_d.endp  = root_word + root_len_words;
                    st_d.done  = 1'b0;
                    st_d.error = 1'b0;
                    st_d.code  = ERR_NONE;
                    if (root_bad) begin
                        st_d.done  = 1'b1;
                        st_d.error = 1'b1;
                        st_d.code  = ERR_ALIGN;
                    end else begin
                        st_d.fsm = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (st_q.ptr == st_q.endp) begin
                    if (stk_empty) begin
                        st_d.fsm  = ST_IDLE;
                        st_d.done = 1'b1;
                    end else begin
                        stk_pop   = 1'b1;
                        st_d.ptr  = top_ret;
                        st_d.endp = top_end;
                    end
                end else begin
                    req_valid = 1'b1;
                    if (req_ready) st_d.fsm = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    st_d.fsm = ST_FETCH;
                    st_d.ptr = st_q.ptr + PTR_W'(1);
                    unique case (ins.kind)
                        K_MOVE64: begin
                            we0 = 1'b1; wi0 = dst9; wd0 = ins.imm48[31:0];
                            we1 = 1'b1; wi1 = dst9 + RIDX_W'(1);
                            wd1 = {16'h0, ins.imm48[47:32]};
                        end
                        K_MOVE32: begin
                            we0 = 1'b1; wi0 = dst9; wd0 = ins.imm32;
                        end
                        K_ADD32: begin
                            we0 = 1'b1; wi0 = dst9; wd0 = rd_data[0] + ins.imm32;
                        end
                        K_ADD64: begin
                            we0 = 1'b1; wi0 = dst9; wd0 = add64_sum[31:0];
                            we1 = 1'b1; wi1 = dst9 + RIDX_W'(1); wd1 = add64_sum[63:32];
                        end
                        K_CALL: begin
                            if (stk_full || tgt_bad) begin
                                st_d.fsm   = ST_IDLE;
                                st_d.done  = 1'b1;
                                st_d.error = 1'b1;
                                st_d.code  = stk_full ? ERR_OVERFLOW : ERR_ALIGN;
                            end else begin
                                stk_push  = 1'b1;
                                st_d.ptr  = tgt_word;
                                st_d.endp = tgt_word + tgt_len_words;
                            end
                        end
                        K_JUMP: begin
                            if (stk_empty || tgt_bad) begin
                                st_d.fsm   = ST_IDLE;
                                st_d.done  = 1'b1;
                                st_d.error = 1'b1;
                                st_d.code  = stk_empty ? ERR_ROOT_JUMP : ERR_ALIGN;
                            end else begin
                                st_d.ptr  = tgt_word;
                                st_d.endp = tgt_word + tgt_len_words;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fsm: ST_IDLE, ptr: '0, endp: '0, done: 1'b0,
                      error: 1'b0, code: ERR_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_addr = st_q.ptr;
    assign dbg_data = rd_data[3];
    assign busy     = (st_q.fsm != ST_IDLE);
    assign done     = st_q.done;
    assign error    = st_q.error;
    assign err_code = st_q.code;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R12
    err_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R12
    done_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || error));

    // R11
    jump_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == ST_WAIT && rsp_valid && ins.kind == K_JUMP) |=> $stable(stk_depth));
endmodule

// File: tb/sim_cseq_top.sv
`timescale 1ns/1ps
module sim_cseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [34:0] start_addr = '0;
    logic [31:0] start_len = '0;
    logic        req_valid, req_ready;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [7:0]  dbg_idx = '0;
    logic [31:0] dbg_data;
    logic        busy, done, error;
    logic [1:0]  err_code;

    always #2.5 clk = ~clk;

    cseq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .busy(busy), .done(done),
        .error(error), .err_code(err_code)
    );

    // fetch memory model
    logic [63:0] mem [0:127];
    logic        mem_en = 1'b1;
    logic        pend, rdy_rand;
    int          lat_cnt;
    logic [63:0] pend_data;
    int          fetch_log [0:1023];
    int          fetch_n;

    assign req_ready = mem_en && !pend && rdy_rand;

    always @(posedge clk) begin
        rdy_rand <= ($urandom_range(0, 3) != 0);
        if (!rst_n) begin
            pend <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0; lat_cnt <= 0; fetch_n <= 0;
            pend_data <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (pend) begin
                if (lat_cnt <= 1) begin
                    rsp_valid <= 1'b1; rsp_data <= pend_data; pend <= 1'b0;
                end else lat_cnt <= lat_cnt - 1;
            end else if (req_valid && req_ready) begin
                pend <= 1'b1;
                pend_data <= mem[req_addr[6:0]];
                lat_cnt <= $urandom_range(1, 3);
                if (fetch_n < 1024) fetch_log[fetch_n] <= int'(req_addr);
                fetch_n <= fetch_n + 1;
            end
        end
    end

    int checks = 0;
    int fails  = 0;
    int base;
    logic [31:0] m [0:15];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] e32(input logic [7:0] op, input logic [7:0] d, input logic [7:0] s, input logic [31:0] imm);
        return {op, d, s, 8'h00, imm};
    endfunction

    function automatic logic [63:0] e48(input logic [7:0] op, input logic [7:0] d, input logic [47:0] imm);
        return {op, d, imm};
    endfunction

    task automatic getr(input int idx, output logic [31:0] v);
        dbg_idx = 8'(idx);
        #1;
        v = dbg_data;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!(done && !busy) && k < 5000) begin
            @(negedge clk);
            k++;
        end
        if (k >= 5000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        end
    endtask

    task automatic run(input logic [34:0] a, input logic [31:0] len);
        @(negedge clk);
        base = fetch_n;
        start_addr = a; start_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic chk_reg(input int idx, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        getr(idx, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic chk_end(input bit ex_err, input logic [1:0] ex_code, input int ex_n, input string tag);
        chk(done == 1'b1, tag, done, 1);
        chk(error == ex_err, tag, error, ex_err);
        chk(err_code == ex_code, tag, err_code, ex_code);
        chk(fetch_n - base == ex_n, tag, fetch_n - base, ex_n);
    endtask

    initial begin
        logic [31:0] v;
        v = $urandom(32'd20240);
        for (int i = 0; i < 128; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!done && !error && !busy && !req_valid, "R1 reset", {done, error, busy, req_valid}, 0);
        chk_reg(0, 32'h0, "R1 reset reg");

        // R2 zero-length root
        run(35'd0, 32'd0);
        chk_end(1'b0, 2'd0, 0, "R2 zero length");
        // R12 done sticky
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R12 sticky", done, 1);

        // R1 misaligned root length
        run(35'd0, 32'd12);
        chk_end(1'b1, 2'd2, 0, "R1 misaligned root");

        // R7 simple call, also clears previous error (R1)
        mem[0] = e48(8'h01, 8'd4, 48'd256);
        mem[1] = e32(8'h02, 8'd6, 8'd0, 32'd16);
        mem[2] = e32(8'h21, 8'd4, 8'd6, 32'd0);
        mem[3] = e32(8'h02, 8'd7, 8'd0, 32'h77);
        mem[32] = e32(8'h02, 8'd8, 8'd0, 32'h88);
        mem[33] = e32(8'h02, 8'd9, 8'd0, 32'h99);
        run(35'd0, 32'd32);
        chk_end(1'b0, 2'd0, 6, "R7 call");
        chk(fetch_log[base+3] == 32 && fetch_log[base+4] == 33 && fetch_log[base+5] == 3,
            "R7 call order", fetch_log[base+5], 3);
        chk_reg(7, 32'h77, "R7 after return");
        chk_reg(8, 32'h88, "R7 callee");
        chk_reg(9, 32'h99, "R7 callee");

        // R8 nested calls ending together
        mem[0] = e48(8'h01, 8'd4, 48'd320);
        mem[1] = e32(8'h02, 8'd6, 8'd0, 32'd8);
        mem[2] = e48(8'h01, 8'd12, 48'd384);
        mem[3] = e32(8'h02, 8'd14, 8'd0, 32'd8);
        mem[4] = e32(8'h21, 8'd4, 8'd6, 32'd0);
        mem[40] = e32(8'h21, 8'd12, 8'd14, 32'd0);
        mem[48] = e32(8'h02, 8'd10, 8'd0, 32'd5);
        run(35'd0, 32'd40);
        chk_end(1'b0, 2'd0, 7, "R8 cascade");
        chk(fetch_log[base+6] == 48, "R8 last fetch", fetch_log[base+6], 48);
        chk_reg(10, 32'd5, "R8 innermost");

        // R9 overflow by self call
        mem[0] = e48(8'h01, 8'd4, 48'd512);
        mem[1] = e32(8'h02, 8'd6, 8'd0, 32'd8);
        mem[2] = e32(8'h21, 8'd4, 8'd6, 32'd0);
        mem[64] = e32(8'h21, 8'd4, 8'd6, 32'd0);
        run(35'd0, 32'd24);
        chk_end(1'b1, 2'd1, 10, "R9 overflow");

        // R10 misaligned call length
        mem[0] = e48(8'h01, 8'd4, 48'd256);
        mem[1] = e32(8'h02, 8'd6, 8'd0, 32'd12);
        mem[2] = e32(8'h21, 8'd4, 8'd6, 32'd0);
        run(35'd0, 32'd24);
        chk_end(1'b1, 2'd2, 3, "R10 align");

        // R11 jump at root
        mem[1] = e32(8'h02, 8'd6, 8'd0, 32'd8);
        mem[2] = e32(8'h20, 8'd4, 8'd6, 32'd0);
        run(35'd0, 32'd24);
        chk_end(1'b1, 2'd3, 3, "R11 root jump");

        // R11 jump inside a call
        mem[0] = e48(8'h01, 8'd4, 48'd640);
        mem[1] = e32(8'h02, 8'd6, 8'd0, 32'd16);
        mem[2] = e48(8'h01, 8'd16, 48'd720);
        mem[3] = e32(8'h02, 8'd18, 8'd0, 32'd8);
        mem[4] = e32(8'h02, 8'd21, 8'd0, 32'd0);
        mem[5] = e32(8'h21, 8'd4, 8'd6, 32'd0);
        mem[6] = e32(8'h02, 8'd20, 8'd0, 32'd1);
        mem[80] = e32(8'h20, 8'd16, 8'd18, 32'd0);
        mem[81] = e32(8'h02, 8'd21, 8'd0, 32'hBAD);
        mem[90] = e32(8'h02, 8'd22, 8'd0, 32'h22);
        run(35'd0, 32'd56);
        chk_end(1'b0, 2'd0, 9, "R11 jump in call");
        chk_reg(21, 32'd0, "R11 skipped word");
        chk_reg(22, 32'h22, "R11 jump target");
        chk_reg(20, 32'd1, "R11 return to root");

        // R12 unknown opcode is a no-op
        mem[0] = e32(8'h02, 8'd24, 8'd0, 32'h5A);
        mem[1] = {8'h7F, 8'd24, 8'd25, 40'h12_3456_789A};
        mem[2] = e32(8'h02, 8'd23, 8'd0, 32'd3);
        run(35'd0, 32'd24);
        chk_end(1'b0, 2'd0, 3, "R12 unknown op");
        chk_reg(24, 32'h5A, "R12 untouched");
        chk_reg(23, 32'd3, "R12 after no-op");

        // R3 R5 R6 directed arithmetic corners
        mem[0] = e48(8'h01, 8'd30, 48'h0000_FFFF_FFFF);
        mem[1] = e32(8'h11, 8'd32, 8'd30, 32'd1);
        mem[2] = e32(8'h11, 8'd34, 8'd36, 32'hFFFF_FFFF);
        mem[3] = e32(8'h10, 8'd38, 8'd30, 32'd2);
        mem[4] = e48(8'h01, 8'd40, 48'hABCD_1234_5678);
        run(35'd0, 32'd40);
        chk_end(1'b0, 2'd0, 5, "R6 arith run");
        chk_reg(32, 32'h0, "R6 carry low");
        chk_reg(33, 32'h1, "R6 carry high");
        chk_reg(34, 32'hFFFF_FFFF, "R6 sext low");
        chk_reg(35, 32'hFFFF_FFFF, "R6 sext high");
        chk_reg(38, 32'h1, "R5 wrap");
        chk_reg(40, 32'h1234_5678, "R3 low");
        chk_reg(41, 32'h0000_ABCD, "R3 high");

        // R12 start while busy is ignored
        mem[0] = e32(8'h02, 8'd25, 8'd0, 32'd9);
        mem_en = 1'b0;
        @(negedge clk);
        base = fetch_n;
        start_addr = 35'd0; start_len = 32'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start_addr = 35'd800; start_len = 32'd16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mem_en = 1'b1;
        wait_done();
        chk_end(1'b0, 2'd0, 1, "R12 start ignored");
        chk(fetch_log[base] == 0, "R12 first fetch", fetch_log[base], 0);
        chk_reg(25, 32'd9, "R12 original run");

        // R3 R4 R5 R6 random straight-line programs on registers 64..79
        for (int r = 0; r < 20; r++) begin
            int n;
            n = $urandom_range(1, 10);
            for (int w = 0; w < n; w++) begin
                int k, d, s;
                logic [31:0] imm;
                logic [47:0] imm48;
                logic [63:0] sum;
                k = $urandom_range(0, 5);
                d = $urandom_range(0, 14);
                s = $urandom_range(0, 14);
                imm = $urandom;
                imm48 = {16'($urandom), 32'($urandom)};
                case (k)
                    0: begin
                        mem[100+w] = e48(8'h01, 8'(64+d), imm48);
                        m[d] = imm48[31:0]; m[d+1] = {16'h0, imm48[47:32]};
                    end
                    1: begin
                        mem[100+w] = e32(8'h02, 8'(64+d), 8'(64+s), imm);
                        m[d] = imm;
                    end
                    2: begin
                        mem[100+w] = e32(8'h10, 8'(64+d), 8'(64+s), imm);
                        m[d] = m[s] + imm;
                    end
                    3: begin
                        mem[100+w] = e32(8'h11, 8'(64+d), 8'(64+s), imm);
                        sum = {m[s+1], m[s]} + {{32{imm[31]}}, imm};
                        m[d] = sum[31:0]; m[d+1] = sum[63:32];
                    end
                    4: mem[100+w] = e32(8'h00, 8'(64+d), 8'(64+s), imm);
                    default: mem[100+w] = e32(8'h44, 8'(64+d), 8'(64+s), imm);
                endcase
            end
            run(35'd800, 32'(n * 8));
            chk_end(1'b0, 2'd0, n, "R4 random run");
            for (int i = 0; i < 16; i++) chk_reg(64 + i, m[i], "R5/R6 random reg");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule